// File: doc/BRIEF.md
# Prescaled 8-bit Downcounting Timer

This peripheral measures time intervals from the internal clock. A fixed divide-by-12 stage produces one advance pulse every twelve clocks. Each pulse steps a 7-bit prescaler that counts down and refills itself with all ones after it reaches zero. A 3-bit tap select picks one of eight division ratios from the prescaler, from 1 to 128 advances, and that ratio steps an 8-bit down counter. When the counter rolls from zero to all ones, a sticky zero flag is set. If the interrupt enable is also set, the block raises an interrupt request. Together the counter and prescaler give a span of up to 2^15 advances.

Software reaches the block through a plain address, write strobe and write data interface, with a read data port decoded from the same address. The prescaler, the counter and a control/status register can each be read and written. The interrupt request is also presented as a wake-up request, so that the timer can end a low-power wait period. The timer runs on the normal clock throughout.

Top module: `pscl_down_timer`

## Requirements
- R1: After reset the prescaler reads 7Fh, the counter reads FFh, the control register reads 00h, and irq_req and wake_req are low.
- R2: The prescaler decrements once every 12 clocks. An advance taken at value 00h reloads it with 7Fh. Without an advance or a write it holds its value.
- R3: A write to address 0 loads bus_wdata[6:0] into the prescaler, and the new value is readable in the next cycle. The write takes precedence over an advance in the same cycle. Bit 7 of address 0 always reads 0.
- R4: With tap value n (control bits [2:0]), the counter steps once per 2^n prescaler advances. For n=0 it steps on every advance. For n≥1 it steps on the advance that takes prescaler bit n-1 from 1 to 0. A prescaler write never produces a step.
- R5: A counter step taken at 00h wraps the counter to FFh and sets the zero flag, which is control bit 7.
- R6: A write to address 1 loads the counter with bus_wdata, and the new value is readable in the next cycle. The write takes precedence over a step in the same cycle, and that step does not set the zero flag.
- R7: The zero flag is cleared only by a write to address 2 with bit 7 at 0. A write with bit 7 at 1 leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: The control register at address 2 holds the tap in bits [2:0], the interrupt enable in bit 3 and the zero flag in bit 7. Bits [6:4] read 0.
- R9: irq_req is high exactly when both the zero flag and the interrupt enable are set, and wake_req always equals irq_req.
- R10: Address 3 reads 00h, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 prescaler, 1 counter, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register selected by bus_addr |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request for the wait state |

## Verification
Two events are hard to produce at the ports. The first is an underflow at the slowest taps, which only happens after thousands of clocks. The second is a write that lands in the same cycle as a prescaler advance, a counter step or an underflow. The bench handles the slow taps by preloading the prescaler with a single bit set just above the selected tap and loading the counter with 1, so two steps come within about 2^n·12 clocks. It then issues bursts of back-to-back writes to the counter, prescaler and control registers while the timer runs at the fastest tap, so that some writes fall on a step or an underflow. A behavioural model compares every register and both outputs on every cycle.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_FLAG_BIT = 7;
endpackage

// File: rtl/pdt_clkdiv.sv
module pdt_clkdiv #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic [W:0]   strobe
);
  logic [W-1:0] val_q, val_d, dec_v;

  always_comb begin
    dec_v = (val_q == '0) ? '1 : val_q - 1'b1;
    val_d = val_q;
    if (load)     val_d = load_val;
    else if (adv) val_d = dec_v;
  end

  // strobe[0]: every advance; strobe[k]: bit k-1 falls on this advance
  assign strobe[0] = adv & ~load;
  generate
    for (genvar k = 1; k <= W; k++) begin : g_tap
      assign strobe[k] = adv & ~load & val_q[k-1] & ~dec_v[k-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '1;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int W  = 8,
  parameter int NS = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] tap,
  input  logic [NS-1:0] strobe,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  output logic [W-1:0]  value,
  output logic          underflow
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  always_comb begin
    step = 1'b0;
    for (int k = 0; k < NS; k++) begin
      if (tap == SW'(k)) step = strobe[k];
    end
  end

  always_comb begin
    underflow = step & ~load & (cnt_q == '0);
    cnt_d     = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/pscl_down_timer.sv
module pscl_down_timer
  import pdt_pkg::*;
#(
  parameter int DIV_RATIO = 12,
  parameter int PSC_W     = 7,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_req,
  output logic             wake_req
);
  localparam int NSTROBE = PSC_W + 1;
  localparam int TAP_W   = $clog2(NSTROBE);

  reg_sel_e         sel;
  logic             wr_psc, wr_cnt, wr_ctl;
  logic             tick;
  logic [PSC_W-1:0] psc_val;
  logic [PSC_W:0]   strobes;
  logic [CNT_W-1:0] cnt_val;
  logic             underflow;

  logic [TAP_W-1:0] tap_q, tap_d;
  logic             en_q, en_d;
  logic             flag_q, flag_d;

  assign sel    = reg_sel_e'(bus_addr);
  assign wr_psc = bus_wr && (sel == SEL_PSC);
  assign wr_cnt = bus_wr && (sel == SEL_CNT);
  assign wr_ctl = bus_wr && (sel == SEL_CTL);

  pdt_clkdiv #(.DIV(DIV_RATIO)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  pdt_prescaler #(.W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (tick),
    .load    (wr_psc),
    .load_val(bus_wdata[PSC_W-1:0]),
    .value   (psc_val),
    .strobe  (strobes)
  );

  pdt_counter #(.W(CNT_W), .NS(NSTROBE), .SW(TAP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap      (tap_q),
    .strobe   (strobes),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .value    (cnt_val),
    .underflow(underflow)
  );

  // control / status next state
  always_comb begin
    tap_d  = tap_q;
    en_d   = en_q;
    flag_d = flag_q;
    if (wr_ctl) begin
      tap_d = bus_wdata[TAP_W-1:0];
      en_d  = bus_wdata[CTL_EN_BIT];
      if (!bus_wdata[CTL_FLAG_BIT]) flag_d = 1'b0;
    end
    if (underflow) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      tap_q  <= tap_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_PSC: bus_rdata[PSC_W-1:0] = psc_val;
      SEL_CNT: bus_rdata = cnt_val;
      SEL_CTL: begin
        bus_rdata[TAP_W-1:0]    = tap_q;
        bus_rdata[CTL_EN_BIT]   = en_q;
        bus_rdata[CTL_FLAG_BIT] = flag_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_req  = flag_q & en_q;
  assign wake_req = irq_req;
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int PSC_W = 7,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [PSC_W-1:0] psc_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             en_q,
  input logic             tick,
  input logic             irq_req,
  input logic             wake_req
);
  logic w_psc, w_cnt, w_ctl;
  assign w_psc = bus_wr && (bus_addr == 2'd0);
  assign w_cnt = bus_wr && (bus_addr == 2'd1);
  assign w_ctl = bus_wr && (bus_addr == 2'd2);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !w_psc) |=> $stable(psc_q)); // R2
  AST_PSC_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !w_psc && psc_q == '0) |=> (psc_q == '1)); // R2
  AST_PSC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    w_psc |=> (psc_q == $past(bus_wdata[PSC_W-1:0]))); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt |=> (cnt_q == $past(bus_wdata))); // R6
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !w_cnt) |=> (cnt_q == '0 || (cnt_q == '1 && flag_q))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(w_ctl && !bus_wdata[7])) |=> flag_q); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q && flag_q)); // R9
  AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req == irq_req); // R9
endmodule

bind pscl_down_timer pdt_checker #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_pdt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .psc_q    (psc_val),
  .cnt_q    (cnt_val),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .tick     (tick),
  .irq_req  (irq_req),
  .wake_req (wake_req)
);

// File: tb/test_pscl_down_timer.sv
`timescale 1ns/1ps
module test_pscl_down_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_req, wake_req;

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;
  int rot    = 0;

  // behavioural model state
  int m_div, m_psc, m_cnt, m_tap, m_en, m_flag;

  always #2 clk = ~clk;

  pscl_down_timer i_pscl_down_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .wake_req(wake_req)
  );

  function automatic int mrd(input int a);
    case (a)
      0: return m_psc;
      1: return m_cnt;
      2: return m_tap | (m_en << 3) | (m_flag << 7);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_psc = 127; m_cnt = 255; m_tap = 0; m_en = 0; m_flag = 0;
    end else begin
      bit tk, w0, w1, w2, stp, uf;
      int old;
      tk = (m_div == 11);
      m_div = tk ? 0 : m_div + 1;
      w0 = bus_wr && bus_addr == 2'd0;
      w1 = bus_wr && bus_addr == 2'd1;
      w2 = bus_wr && bus_addr == 2'd2;
      old = m_psc;
      if (w0) m_psc = bus_wdata & 127;
      else if (tk) m_psc = (old == 0) ? 127 : old - 1;
      stp = 0;
      if (tk && !w0) begin
        if (m_tap == 0) stp = 1;
        else stp = (((old >> (m_tap - 1)) & 1) == 1) && (((m_psc >> (m_tap - 1)) & 1) == 0);
      end
      uf = stp && !w1 && m_cnt == 0;
      if (w1) m_cnt = bus_wdata;
      else if (stp) m_cnt = (m_cnt + 255) % 256;
      if (w2) begin
        m_tap = bus_wdata & 7;
        m_en  = (bus_wdata >> 3) & 1;
        if (bus_wdata[7] == 1'b0) m_flag = 0;
      end
      if (uf) m_flag = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run) begin
      case (bus_addr)
        2'd0: chk("R2 prescaler", bus_rdata, mrd(0));
        2'd1: chk("R4 counter", bus_rdata, mrd(1));
        2'd2: chk("R8 control", bus_rdata, mrd(2));
        default: chk("R10 unused address", bus_rdata, 0);
      endcase
      chk("R9 irq_req", irq_req, m_flag & m_en);
      chk("R9 wake_req", wake_req, m_flag & m_en);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_addr = a[1:0]; bus_wdata = d[7:0]; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      bus_addr = rot[1:0];
      rot = (rot + 1) % 4;
    end
  endtask

  // look at a register right after the last edge, no extra edge taken
  task automatic peek(input int a, input string req, input int exp_v);
    bus_addr = a[1:0];
    @(negedge clk);
    chk(req, bus_rdata, exp_v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    peek(0, "R1 prescaler reset", 8'h7F);
    peek(1, "R1 counter reset", 8'hFF);
    peek(2, "R1 control reset", 8'h00);
    peek(3, "R1 unused reset", 8'h00);
    chk("R1 irq reset", irq_req, 0);
    run = 1'b1;

    // R2 free advance and refill through zero
    idle(40);
    wr(0, 8'h85);
    peek(0, "R3 prescaler load, bit7 reads 0", 8'h05);
    idle(120);

    // R5 underflow at tap 0 with enable
    wr(2, 8'h08);
    wr(1, 3);
    peek(1, "R6 counter load", 3);
    idle(60);
    peek(2, "R5 flag set after wrap", 8'h88);
    chk("R9 irq with enable", irq_req, 1);
    chk("R9 wake with enable", wake_req, 1);

    // R7 sticky flag
    wr(2, 8'h88);
    peek(2, "R7 write with bit7=1 keeps flag", 8'h88);
    wr(2, 8'h08);
    peek(2, "R7 write with bit7=0 clears flag", 8'h08);

    // R9 flag without enable
    wr(2, 8'h00);
    wr(1, 0);
    idle(30);
    peek(2, "R9 flag set, enable low", 8'h80);
    chk("R9 irq masked", irq_req, 0);

    // R4 each tap, prescaler preloaded just above the tap bit
    for (int t = 1; t <= 7; t++) begin
      wr(2, t);
      wr(1, 1);
      wr(0, 1 << (t - 1));
      idle(12 * ((1 << t) + 2) + 10);
      peek(2, "R4 tap underflow reached", 8'h80 | t);
    end

    // R6 / R3 / R7 write collisions at the fastest tap
    wr(2, 8'h08);
    for (int i = 0; i < 40; i++) begin
      wr(1, i % 2);
      idle(i % 5);
    end
    for (int i = 0; i < 30; i++) begin
      wr(2, 8'h08);
      wr(0, i * 5);
    end
    wr(2, 8'h09);
    for (int i = 0; i < 60; i++) wr(0, i * 3);

    // R10 writes to address 3 leave all state untouched
    wr(2, 8'h00);
    wr(1, 8'h40);
    wr(3, 8'hFF);
    peek(2, "R10 control untouched", 8'h00);
    peek(3, "R10 unused reads zero", 8'h00);
    idle(50);

    run = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule